// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character at a time into a serial frame on a single line. Each frame has a low start bit. The data bits follow, least significant first. An optional parity bit comes next, then one or two high stop bits. Character size, parity kind and stop count are inputs sampled at run time. A one-entry holding register with a valid/ready handshake lets the next character wait while the current frame shifts out. Consecutive frames therefore run with no idle time between them.

Bit timing comes from one of two sources. In asynchronous mode, a one-cycle tick from an external baud generator moves the frame forward by one bit. In synchronous mode, an external serial clock is synchronised into the system clock domain and edge-detected. A polarity input chooses whether the line changes on the rising or the falling edge of that clock.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd_o` is 1, `busy_o` is 0 and `ready_o` is 1 while the holding register is empty.
- R2: A frame starts with a single low start bit. The data bits follow, bit 0 first. The number of data bits comes from the 4-bit `char_size_i`: values 5, 6, 7, 8 and 9 give that many bits, and any other value gives 8. Data bits above that count are not sent.
- R3: `parity_mode_i` selects the parity bit: 2'b00 and 2'b01 send none, 2'b10 sends even parity and 2'b11 sends odd parity. Even parity is the XOR of the data bits actually sent, and odd parity is its inverse. The parity bit goes between the last data bit and the first stop bit.
- R4: `stop2_i` = 0 sends one stop bit and `stop2_i` = 1 sends two. Stop bits are high. The frame length is 1 + data bits + parity bit (0 or 1) + stop bits.
- R5: Each bit lasts exactly one step. `txd_o` changes only at the clock edge where a step is taken.
- R6: A character is accepted at the clock edge where both `valid_i` and `ready_o` are 1. `ready_o` is high exactly when the holding register is empty. A waiting character starts its frame on the same step that ends the previous frame's last stop bit, so no idle bit is inserted.
- R7: `busy_o` is high from the start bit until the step that ends the last stop bit. At that step `done_o` pulses for exactly one cycle.
- R8: Character size, parity mode and stop count are sampled when the start bit is taken. Changes made during a frame affect only later frames.
- R9: When `sync_mode_i` = 1, a step is a synchronised edge of `xck_i`: the rising edge if `clk_pol_i` = 0, the falling edge if `clk_pol_i` = 1. In this mode `bit_tick_i` is ignored.
- R10: When `sync_mode_i` = 0, a step is a cycle in which `bit_tick_i` = 1. In this mode `xck_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1: step on the serial clock, 0: step on the bit tick |
| clk_pol_i | input | 1 | Serial clock edge that changes data: 0 rising, 1 falling |
| bit_tick_i | input | 1 | One-cycle bit strobe from the baud generator |
| xck_i | input | 1 | External serial clock, asynchronous to clk_i |
| char_size_i | input | 4 | Data bits per character (5..9, otherwise 8) |
| parity_mode_i | input | 2 | 00/01 none, 10 even, 11 odd |
| stop2_i | input | 1 | 0: one stop bit, 1: two stop bits |
| data_i | input | 9 | Character to send |
| valid_i | input | 1 | Character on data_i is valid |
| ready_o | output | 1 | Holding register is empty |
| txd_o | output | 1 | Serial data line |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
In asynchronous mode, `txd_o` is registered and takes each new bit at the same edge that sees `bit_tick_i`. The bench therefore raises the tick on a falling clock edge and reads the line at the next falling edge. `done_o` and the return to idle appear in the cycle after the tick that ends the last stop bit, and one cycle later `done_o` must be low again. In synchronous mode, a change on `xck_i` takes two synchroniser flops plus one edge-detect flop to reach the line, so it appears at the third rising edge of the system clock. The bench holds each half-period of `xck_i` for four system cycles and samples at the end. It also checks that the line did not move on the opposite edge. A character is in the holding register one edge after the handshake, so `ready_o` is checked one cycle after a push.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
package sft_pkg;
  localparam int unsigned MAX_DATA  = 9;
  localparam int unsigned MIN_DATA  = 5;
  localparam int unsigned DFLT_DATA = 8;
  localparam int unsigned SIZE_W    = 4;
  localparam int unsigned FRAME_MAX = MAX_DATA + 4;  // start + data + parity + 2 stop
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_RSVD = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_ODD  = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [FRAME_MAX-1:0] bits;
    logic [CNT_W-1:0]     len;
  } frame_t;

  function automatic logic [SIZE_W-1:0] decode_size(input logic [SIZE_W-1:0] code);
    if (code >= SIZE_W'(MIN_DATA) && code <= SIZE_W'(MAX_DATA)) return code;
    return SIZE_W'(DFLT_DATA);
  endfunction
endpackage

// File: rtl/sft_step.sv
`timescale 1ns/1ps
module sft_step #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_mode_i,
  input  logic clk_pol_i,
  input  logic tick_i,
  input  logic xck_i,
  output logic step_o
);
  logic xck_s, xck_prev_q, xck_rise, xck_fall;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= 1'b0;
        else         q <= xck_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= 1'b0;
        else         q <= g_sync[g-1].q;
    end
  end

  assign xck_s = g_sync[SYNC_STAGES-1].q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) xck_prev_q <= 1'b0;
    else         xck_prev_q <= xck_s;

  assign xck_rise = xck_s & ~xck_prev_q;
  assign xck_fall = ~xck_s & xck_prev_q;

  always_comb begin
    if (sync_mode_i) step_o = clk_pol_i ? xck_fall : xck_rise;
    else             step_o = tick_i;
  end
endmodule

// File: rtl/sft_hold.sv
`timescale 1ns/1ps
module sft_hold
  import sft_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [MAX_DATA-1:0] data_i,
  input  logic                take_i,
  output logic                ready_o,
  output logic                hold_valid_o,
  output logic [MAX_DATA-1:0] hold_data_o
);
  logic                hold_valid_q;
  logic [MAX_DATA-1:0] hold_data_q;

  assign ready_o      = ~hold_valid_q;
  assign hold_valid_o = hold_valid_q;
  assign hold_data_o  = hold_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_valid_q <= 1'b0;
      hold_data_q  <= '0;
    end else begin
      if (take_i) hold_valid_q <= 1'b0;
      if (valid_i && ready_o) begin
        hold_valid_q <= 1'b1;
        hold_data_q  <= data_i;
      end
    end
  end

  assert_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> hold_valid_q && hold_data_q == $past(data_i));

  assert_take_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> hold_valid_q);
endmodule

// File: rtl/sft_frame_build.sv
`timescale 1ns/1ps
module sft_frame_build
  import sft_pkg::*;
(
  input  logic [MAX_DATA-1:0] data_i,
  input  logic [SIZE_W-1:0]   size_i,
  input  logic [1:0]          par_mode_i,
  input  logic                stop2_i,
  output frame_t              frame_o
);
  logic [SIZE_W-1:0] n_bits;
  logic              par_en, par_bit;

  always_comb begin
    n_bits        = decode_size(size_i);
    par_en        = par_mode_i[1];
    par_bit       = 1'b0;
    frame_o.bits  = '1;
    frame_o.bits[0] = 1'b0;
    for (int i = 0; i < int'(MAX_DATA); i++) begin
      if (i < int'(n_bits)) begin
        frame_o.bits[i+1] = data_i[i];
        par_bit           = par_bit ^ data_i[i];
      end
    end
    if (par_mode_i == PAR_ODD) par_bit = ~par_bit;
    if (par_en) frame_o.bits[int'(n_bits) + 1] = par_bit;
    frame_o.len = CNT_W'(int'(n_bits) + 2 + int'(par_en) + int'(stop2_i));
  end
endmodule

// File: rtl/sft_shift.sv
`timescale 1ns/1ps
module sft_shift
  import sft_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   step_i,
  input  logic   hold_valid_i,
  input  frame_t frame_i,
  output logic   take_o,
  output logic   txd_o,
  output logic   busy_o,
  output logic   done_o
);
  logic                 active_q, txd_q, done_q;
  logic [FRAME_MAX-1:0] sh_q;
  logic [CNT_W-1:0]     cnt_q;   // bits still to send after the current one
  logic                 last_bit;

  assign last_bit = ~active_q | (cnt_q == '0);
  assign take_o   = step_i & hold_valid_i & last_bit;
  assign txd_o    = txd_q;
  assign busy_o   = active_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      txd_q    <= 1'b1;
      done_q   <= 1'b0;
      sh_q     <= '1;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (step_i) begin
        if (!last_bit) begin
          txd_q <= sh_q[0];
          sh_q  <= {1'b1, sh_q[FRAME_MAX-1:1]};
          cnt_q <= cnt_q - 1'b1;
        end else begin
          if (active_q) done_q <= 1'b1;
          if (hold_valid_i) begin
            // frame image is fixed here: later config changes cannot reach it
            txd_q    <= frame_i.bits[0];
            sh_q     <= {1'b1, frame_i.bits[FRAME_MAX-1:1]};
            cnt_q    <= frame_i.len - 1'b1;
            active_q <= 1'b1;
          end else begin
            txd_q    <= 1'b1;
            active_q <= 1'b0;
          end
        end
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> txd_q);

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> !txd_q);

  assert_no_step_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(txd_q));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_busy_end_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> done_q);
endmodule

// File: rtl/serial_frame_tx.sv
`timescale 1ns/1ps
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_mode_i,
  input  logic                clk_pol_i,
  input  logic                bit_tick_i,
  input  logic                xck_i,
  input  logic [SIZE_W-1:0]   char_size_i,
  input  logic [1:0]          parity_mode_i,
  input  logic                stop2_i,
  input  logic [MAX_DATA-1:0] data_i,
  input  logic                valid_i,
  output logic                ready_o,
  output logic                txd_o,
  output logic                busy_o,
  output logic                done_o
);
  logic                step, take, hold_valid;
  logic [MAX_DATA-1:0] hold_data;
  frame_t              frame;

  sft_step #(.SYNC_STAGES(SYNC_STAGES)) u_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_mode_i (sync_mode_i),
    .clk_pol_i   (clk_pol_i),
    .tick_i      (bit_tick_i),
    .xck_i       (xck_i),
    .step_o      (step)
  );

  sft_hold u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .data_i       (data_i),
    .take_i       (take),
    .ready_o      (ready_o),
    .hold_valid_o (hold_valid),
    .hold_data_o  (hold_data)
  );

  sft_frame_build u_build (
    .data_i     (hold_data),
    .size_i     (char_size_i),
    .par_mode_i (parity_mode_i),
    .stop2_i    (stop2_i),
    .frame_o    (frame)
  );

  sft_shift u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (step),
    .hold_valid_i (hold_valid),
    .frame_i      (frame),
    .take_o       (take),
    .txd_o        (txd_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );
endmodule

// File: tb/sim_serial_frame_tx.sv
`timescale 1ns/1ps
module sim_serial_frame_tx;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sync_mode = 1'b0, clk_pol = 1'b0, tick = 1'b0, xck = 1'b0;
  logic [3:0] char_size = 4'd8;
  logic [1:0] par_mode = 2'b00;
  logic       stop2 = 1'b0;
  logic [8:0] data = '0;
  logic       valid = 1'b0;
  logic       ready, txd, busy, done;
  int         checks = 0, errors = 0;

  always #2 clk = ~clk;

  serial_frame_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode), .clk_pol_i(clk_pol),
    .bit_tick_i(tick), .xck_i(xck), .char_size_i(char_size),
    .parity_mode_i(par_mode), .stop2_i(stop2), .data_i(data), .valid_i(valid),
    .ready_o(ready), .txd_o(txd), .busy_o(busy), .done_o(done)
  );

  // {data, size, parity, stop2, expected length}
  localparam logic [19:0] VECS [8] = '{
    {9'h0A5, 4'd8,  2'b00, 1'b0, 4'd10},
    {9'h0FF, 4'd5,  2'b10, 1'b0, 4'd8},
    {9'h155, 4'd9,  2'b11, 1'b1, 4'd13},
    {9'h033, 4'd6,  2'b11, 1'b0, 4'd9},
    {9'h07F, 4'd7,  2'b10, 1'b1, 4'd11},
    {9'h1FF, 4'd3,  2'b00, 1'b1, 4'd11},
    {9'h1AA, 4'd9,  2'b10, 1'b0, 4'd12},
    {9'h016, 4'd12, 2'b01, 1'b0, 4'd10}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [8:0] d, input logic [3:0] cs,
                                    input logic [1:0] pm, input logic st,
                                    output logic [31:0] v, output int len);
    int  n, pos;
    logic p;
    n = (cs >= 4'd5 && cs <= 4'd9) ? int'(cs) : 8;
    v = '1; v[0] = 1'b0; p = 1'b0;
    for (int i = 0; i < n; i++) begin v[1+i] = d[i]; p ^= d[i]; end
    pos = 1 + n;
    if (pm[1]) begin v[pos] = pm[0] ? ~p : p; pos++; end
    len = pos + 1 + int'(st);
  endfunction

  task automatic push(input logic [8:0] d);
    while (!ready) @(negedge clk);
    valid = 1'b1; data = d;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic tick_once();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic run_frame(input logic [8:0] d, input logic [3:0] cs,
                           input logic [1:0] pm, input logic st, input int tlen);
    logic [31:0] ev, gv;
    int el;
    exp_frame(d, cs, pm, st, ev, el);
    chk(el == tlen, "R4", "frame length", el, tlen);
    char_size = cs; par_mode = pm; stop2 = st;
    push(d);
    gv = '1;
    for (int b = 0; b < el; b++) begin
      tick_once();
      gv[b] = txd;
      if (b == 0) begin
        chk(busy, "R7", "busy during frame", busy, 1);
        repeat (3) @(negedge clk);
        chk(txd == 1'b0, "R5", "start bit held without step", txd, 0);
      end
    end
    chk(gv == ev, "R2 R3 R4", "frame bits", gv, ev);
    tick_once();
    chk(done == 1'b1, "R7", "done at frame end", done, 1);
    chk(txd && !busy, "R1", "idle after frame", {busy, txd}, 2'b01);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done lasts one cycle", done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] ev, ev2, gv, stream;
    int el, el2;
    logic prev;

    repeat (3) @(negedge clk);
    chk(txd && !busy && !done, "R1", "reset line state", {done, busy, txd}, 3'b001);
    chk(ready, "R1", "ready after reset", ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table-driven frames, async mode
    for (int k = 0; k < 8; k++) begin
      logic [19:0] e;
      e = VECS[k];
      run_frame(e[19:11], e[10:7], e[6:5], e[4], int'(e[3:0]));
    end

    // back-to-back frames with no gap (R6)
    char_size = 4'd8; par_mode = 2'b00; stop2 = 1'b0;
    exp_frame(9'h03C, 4'd8, 2'b00, 1'b0, ev, el);
    exp_frame(9'h0C3, 4'd8, 2'b00, 1'b0, ev2, el2);
    stream = {ev2[9:0], ev[9:0]};
    push(9'h03C);
    gv = '1;
    tick_once(); gv[0] = txd;
    chk(ready, "R6", "holding register freed at start", ready, 1);
    push(9'h0C3);
    chk(!ready, "R6", "holding register full", ready, 0);
    for (int b = 1; b < 20; b++) begin
      tick_once(); gv[b] = txd;
      if (b == 10) chk(done && busy, "R6", "gapless handover", {done, busy}, 2'b11);
    end
    chk(gv[19:0] == stream[19:0], "R6", "back-to-back stream", gv[19:0], stream[19:0]);
    tick_once();
    chk(done && !busy && txd, "R7", "second frame end", {done, busy, txd}, 3'b101);
    @(negedge clk);

    // config change mid-frame (R8)
    exp_frame(9'h05A, 4'd8, 2'b00, 1'b0, ev, el);
    push(9'h05A);
    gv = '1;
    for (int b = 0; b < el; b++) begin
      tick_once(); gv[b] = txd;
      if (b == 2) begin char_size = 4'd5; par_mode = 2'b11; stop2 = 1'b1; end
    end
    chk(gv == ev, "R8", "frame keeps start config", gv, ev);
    tick_once();
    chk(done, "R8", "frame length unchanged", done, 1);
    @(negedge clk);

    // async mode ignores xck (R10)
    char_size = 4'd8; par_mode = 2'b00; stop2 = 1'b0;
    exp_frame(9'h081, 4'd8, 2'b00, 1'b0, ev, el);
    push(9'h081);
    for (int r = 0; r < 3; r++) begin
      xck = 1'b1; repeat (3) @(negedge clk);
      xck = 1'b0; repeat (3) @(negedge clk);
      chk(txd && !busy, "R10", "xck ignored in async mode", {busy, txd}, 2'b01);
    end
    gv = '1;
    for (int b = 0; b < el; b++) begin tick_once(); gv[b] = txd; end
    chk(gv == ev, "R10", "frame after xck toggles", gv, ev);
    tick_once();
    @(negedge clk);

    // sync mode, polarity 0: change on rising xck (R9)
    sync_mode = 1'b1; clk_pol = 1'b0; xck = 1'b0;
    char_size = 4'd7; par_mode = 2'b10; stop2 = 1'b1;
    exp_frame(9'h02D, 4'd7, 2'b10, 1'b1, ev, el);
    repeat (4) @(negedge clk);
    push(9'h02D);
    tick_once();
    repeat (2) @(negedge clk);
    chk(txd && !busy, "R9", "bit tick ignored in sync mode", {busy, txd}, 2'b01);
    gv = '1;
    for (int b = 0; b < el; b++) begin
      xck = 1'b1; repeat (4) @(negedge clk);
      gv[b] = txd;
      xck = 1'b0; repeat (4) @(negedge clk);
      chk(txd == gv[b], "R9", "no change on falling edge (pol 0)", txd, gv[b]);
    end
    chk(gv == ev, "R9", "sync frame pol 0", gv, ev);
    xck = 1'b1; repeat (4) @(negedge clk);
    chk(txd && !busy, "R9", "idle after sync frame", {busy, txd}, 2'b01);
    xck = 1'b0; repeat (4) @(negedge clk);

    // sync mode, polarity 1: change on falling xck (R9)
    clk_pol = 1'b1;
    char_size = 4'd9; par_mode = 2'b11; stop2 = 1'b0;
    exp_frame(9'h1C6, 4'd9, 2'b11, 1'b0, ev, el);
    push(9'h1C6);
    gv = '1; prev = 1'b1;
    for (int b = 0; b < el; b++) begin
      xck = 1'b1; repeat (4) @(negedge clk);
      chk(txd == prev, "R9", "no change on rising edge (pol 1)", txd, prev);
      xck = 1'b0; repeat (4) @(negedge clk);
      gv[b] = txd; prev = txd;
    end
    chk(gv == ev, "R9", "sync frame pol 1", gv, ev);
    xck = 1'b1; repeat (4) @(negedge clk);
    xck = 1'b0; repeat (4) @(negedge clk);
    chk(txd && !busy, "R9", "idle after pol 1 frame", {busy, txd}, 2'b01);
    sync_mode = 1'b0;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule